// File: doc/BRIEF.md
# Home-Node Snoop Filter Controller

This block sits at the home node of a small shared-memory system of two to eight sockets. Every read request for a line owned by this node arrives here, never at the other sockets. The controller keeps a small set-associative directory that records, for each tracked line, which socket most recently took it. When filtering is active, a request whose line is held by another socket produces a single targeted probe to that holder. A request for a line that no other socket holds is served from local memory with no probe at all. When filtering is inactive, every socket except the home is probed, and the request waits for all of the replies.

A two-bit mode input selects whether filtering is active. The auto setting turns it on only when the configured socket count is above two, because with two sockets a broadcast reaches only one peer anyway. Outstanding requests are held in a table indexed by transaction ID. The table counts the replies still owed, raises a one-cycle completion pulse when the count drains, and at that same edge records the requester as the new holder of the line. If a new line maps to a set whose ways are all occupied, the controller picks a victim entry and sends one invalidating probe to that entry's holder before the way is reused.

Top module: `pf_home`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `probe_vec_o`, `mem_rd_o` and `done_valid_o` are all zero.
- R2: With filtering off, a request probes every node whose index is below `sockets_i`, except the home node. Each probe is non-invalidating (`probe_inv_o`=0) and `mem_rd_o` is 1. Completion waits for one response per probed node plus one for the home node.
- R3: Mode encoding: 0 = filter off, 1 = auto (filter on only when `sockets_i` > 2), 2 = filter forced on, 3 = treated as off.
- R4: With filtering on, a directory hit whose recorded holder differs from the requester sends exactly one non-invalidating probe, to that holder. `mem_rd_o` is 0 and completion waits for one response.
- R5: With filtering on, a directory miss into a set that still has a free way sends no probe. `mem_rd_o` is 1 and the request needs zero responses.
- R6: With filtering on, a hit whose recorded holder is the requester itself behaves like R5: no probe, memory read, zero responses.
- R7: With filtering on, a miss into a full set sends one invalidating probe (`probe_inv_o`=1) to the victim's holder. `probe_addr_o` carries the victim's line address, formed as tag times the set count plus the set index. The set's victim pointer then advances round-robin over the ways, starting at way 0 after reset. Completion waits for one response.
- R8: At completion of a request accepted with filtering on, the directory records the requester as holder of the requested line, in the hit way, the first free way, or the victim way.
- R9: When the last owed response is sampled at edge m, `done_valid_o` is high for exactly the one cycle after edge m+1, carrying the request's ID on `done_tid_o` and requester on `done_node_o`. A zero-response request completes one edge after acceptance.
- R10: A request accepted with filtering off leaves the directory contents unchanged.
- R11: Responses are counted per transaction ID. Two overlapping requests complete in the order their own responses drain. When several complete in the same cycle, the lowest ID is reported first.
- R12: Probes appear in the cycle after the request is sampled, with `probe_tid_o` equal to the request's ID. For non-invalidating probes, `probe_addr_o` equals the request address. Addresses use the low log2(set count) bits as the set index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Filter mode (R3 encoding) |
| sockets_i | input | clog2(NODES+1) | Configured socket count |
| req_valid_i | input | 1 | Read request present this cycle |
| req_node_i | input | clog2(NODES) | Requesting node |
| req_tid_i | input | clog2(NTID) | Transaction ID of the request |
| req_addr_i | input | AW | Line address |
| rsp_valid_i | input | 1 | One probe response this cycle |
| rsp_tid_i | input | clog2(NTID) | Transaction ID of the response |
| probe_vec_o | output | NODES | One bit per node receiving a probe |
| probe_inv_o | output | 1 | Probe invalidates the holder's copy |
| probe_tid_o | output | clog2(NTID) | Transaction ID carried by the probe |
| probe_addr_o | output | AW | Line address carried by the probe |
| mem_rd_o | output | 1 | Home memory supplies the data |
| done_valid_o | output | 1 | Completion pulse to the requester |
| done_tid_o | output | clog2(NTID) | Completed transaction ID |
| done_node_o | output | clog2(NODES) | Requester being released |

## Verification
The bench walks one set through the full sequence of fill, conflict and reuse. A design whose victim pointer does not rotate would invalidate the same way twice, and a design that wrote the directory at acceptance instead of completion would direct later probes at the wrong holder. It switches between filter-off, auto at two and three sockets, and the reserved mode. Decoding auto against the wrong threshold, or letting broadcasts rewrite the directory, would then turn a directed probe into a broadcast or send it to a stale node. It also overlaps two IDs and returns their responses out of order. A shared response counter would release the wrong requester or release it early. Every completion is timed to the exact cycle, so one counted response too few or too many shows up as an early or late pulse.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    PF_OFF   = 2'd0,
    PF_AUTO  = 2'd1,
    PF_FORCE = 2'd2,
    PF_RSVD  = 2'd3
  } pf_mode_e;
endpackage

// File: rtl/pf_mode.sv
module pf_mode
  import pf_pkg::*;
#(
  parameter int SCW = 3
) (
  input  logic [1:0]     mode_i,
  input  logic [SCW-1:0] sockets_i,
  output logic           filt_on_o
);
  pf_mode_e mode;
  assign mode = pf_mode_e'(mode_i);

  always_comb begin
    case (mode)
      PF_AUTO:  filt_on_o = (sockets_i > SCW'(2));
      PF_FORCE: filt_on_o = 1'b1;
      default:  filt_on_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pf_dir.sv
module pf_dir #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  parameter int TW   = 6,
  parameter int NW   = 2,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] lk_set_i,
  input  logic [TW-1:0] lk_tag_i,
  output logic          lk_hit_o,
  output logic [WW-1:0] lk_hit_way_o,
  output logic [NW-1:0] lk_owner_o,
  output logic          lk_free_o,
  output logic [WW-1:0] lk_alloc_way_o,
  output logic [TW-1:0] vic_tag_o,
  output logic [NW-1:0] vic_owner_o,
  input  logic          adv_en_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_set_i,
  input  logic [WW-1:0] wr_way_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [NW-1:0] wr_owner_i
);
  logic [WAYS-1:0] val_q [SETS];
  logic [WW-1:0]   rr_q  [SETS];
  logic [TW-1:0]   tag_q [SETS][WAYS];
  logic [NW-1:0]   own_q [SETS][WAYS];

  logic [WW-1:0] rr_cur, rr_nx, free_way;

  // victim pointer of the looked-up set and its round-robin successor
  always_comb begin
    rr_cur = rr_q[lk_set_i];
    rr_nx  = (rr_cur == WW'(WAYS-1)) ? '0 : rr_cur + 1'b1;
  end

  // tag compare across the ways, first free way as allocation target
  always_comb begin
    lk_hit_o     = 1'b0;
    lk_hit_way_o = '0;
    lk_owner_o   = '0;
    lk_free_o    = 1'b0;
    free_way     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (val_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i) && !lk_hit_o) begin
        lk_hit_o     = 1'b1;
        lk_hit_way_o = WW'(w);
        lk_owner_o   = own_q[lk_set_i][w];
      end
      if (!val_q[lk_set_i][w] && !lk_free_o) begin
        lk_free_o = 1'b1;
        free_way  = WW'(w);
      end
    end
    lk_alloc_way_o = lk_free_o ? free_way : rr_cur;
    vic_tag_o      = tag_q[lk_set_i][rr_cur];
    vic_owner_o    = own_q[lk_set_i][rr_cur];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      if (wr_en_i)  val_q[wr_set_i][wr_way_i] <= 1'b1;
      if (adv_en_i) rr_q[lk_set_i]            <= rr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
      own_q[wr_set_i][wr_way_i] <= wr_owner_i;
    end
  end
endmodule

// File: rtl/pf_txn.sv
module pf_txn #(
  parameter int NTID = 4,
  parameter int NW   = 2,
  parameter int SW   = 2,
  parameter int WW   = 1,
  parameter int TW   = 6,
  parameter int CW   = 3,
  localparam int IW  = $clog2(NTID)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en_i,
  input  logic [IW-1:0] alloc_tid_i,
  input  logic [CW-1:0] alloc_cnt_i,
  input  logic [NW-1:0] alloc_node_i,
  input  logic          alloc_upd_i,
  input  logic [SW-1:0] alloc_set_i,
  input  logic [WW-1:0] alloc_way_i,
  input  logic [TW-1:0] alloc_tag_i,
  input  logic          rsp_valid_i,
  input  logic [IW-1:0] rsp_tid_i,
  output logic          done_valid_o,
  output logic [IW-1:0] done_tid_o,
  output logic [NW-1:0] done_node_o,
  output logic          dw_en_o,
  output logic [SW-1:0] dw_set_o,
  output logic [WW-1:0] dw_way_o,
  output logic [TW-1:0] dw_tag_o,
  output logic [NW-1:0] dw_owner_o
);
  logic [NTID-1:0] v_q, v_d, upd_q;
  logic [CW-1:0]   cnt_q  [NTID];
  logic [CW-1:0]   cnt_d  [NTID];
  logic [NW-1:0]   node_q [NTID];
  logic [SW-1:0]   set_q  [NTID];
  logic [WW-1:0]   way_q  [NTID];
  logic [TW-1:0]   tag_q  [NTID];

  logic          sel_found;
  logic [IW-1:0] sel_idx;
  logic          done_q;
  logic [IW-1:0] done_tid_q;
  logic [NW-1:0] done_node_q;

  // lowest live ID with nothing owed completes this cycle
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int t = 0; t < NTID; t++) begin
      if (v_q[t] && (cnt_q[t] == '0) && !sel_found) begin
        sel_found = 1'b1;
        sel_idx   = IW'(t);
      end
    end
  end

  always_comb begin
    v_d   = v_q;
    cnt_d = cnt_q;
    if (sel_found) v_d[sel_idx] = 1'b0;
    if (rsp_valid_i && v_q[rsp_tid_i] && (cnt_q[rsp_tid_i] != '0))
      cnt_d[rsp_tid_i] = cnt_q[rsp_tid_i] - 1'b1;
    if (alloc_en_i) begin
      v_d[alloc_tid_i]   = 1'b1;
      cnt_d[alloc_tid_i] = alloc_cnt_i;
    end
  end

  assign dw_en_o    = sel_found && upd_q[sel_idx];
  assign dw_set_o   = set_q[sel_idx];
  assign dw_way_o   = way_q[sel_idx];
  assign dw_tag_o   = tag_q[sel_idx];
  assign dw_owner_o = node_q[sel_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      done_q <= 1'b0;
      for (int t = 0; t < NTID; t++) cnt_q[t] <= '0;
    end else begin
      v_q    <= v_d;
      cnt_q  <= cnt_d;
      done_q <= sel_found;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en_i) begin
      node_q[alloc_tid_i] <= alloc_node_i;
      upd_q[alloc_tid_i]  <= alloc_upd_i;
      set_q[alloc_tid_i]  <= alloc_set_i;
      way_q[alloc_tid_i]  <= alloc_way_i;
      tag_q[alloc_tid_i]  <= alloc_tag_i;
    end
    if (sel_found) begin
      done_tid_q  <= sel_idx;
      done_node_q <= node_q[sel_idx];
    end
  end

  assign done_valid_o = done_q;
  assign done_tid_o   = done_tid_q;
  assign done_node_o  = done_node_q;
endmodule

// File: rtl/pf_home.sv
module pf_home
  import pf_pkg::*;
#(
  parameter int NODES = 4,
  parameter int HOME  = 1,
  parameter int AW    = 8,
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int NTID  = 4,
  localparam int NW   = $clog2(NODES),
  localparam int SCW  = $clog2(NODES + 1),
  localparam int CW   = $clog2(NODES + 1),
  localparam int SW   = $clog2(SETS),
  localparam int TW   = AW - SW,
  localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IW   = $clog2(NTID)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [SCW-1:0]   sockets_i,
  input  logic             req_valid_i,
  input  logic [NW-1:0]    req_node_i,
  input  logic [IW-1:0]    req_tid_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             rsp_valid_i,
  input  logic [IW-1:0]    rsp_tid_i,
  output logic [NODES-1:0] probe_vec_o,
  output logic             probe_inv_o,
  output logic [IW-1:0]    probe_tid_o,
  output logic [AW-1:0]    probe_addr_o,
  output logic             mem_rd_o,
  output logic             done_valid_o,
  output logic [IW-1:0]    done_tid_o,
  output logic [NW-1:0]    done_node_o
);
  logic          filt;
  logic [SW-1:0] lk_set;
  logic [TW-1:0] lk_tag;
  logic          hit, free;
  logic [WW-1:0] hit_way, alloc_way, way_sel;
  logic [NW-1:0] owner, vic_owner;
  logic [TW-1:0] vic_tag;
  logic          dw_en;
  logic [SW-1:0] dw_set;
  logic [WW-1:0] dw_way;
  logic [TW-1:0] dw_tag;
  logic [NW-1:0] dw_owner;

  logic [NODES-1:0] bmask, pv_d, probe_vec_q;
  logic             directed, evict, inv_d, mem_d, inv_q, mem_q;
  logic [CW-1:0]    cnt_d;
  logic [AW-1:0]    paddr_d, paddr_q;
  logic [IW-1:0]    ptid_q;

  assign lk_set = req_addr_i[SW-1:0];
  assign lk_tag = req_addr_i[AW-1:SW];

  pf_mode #(.SCW(SCW)) u_mode (
    .mode_i(mode_i), .sockets_i(sockets_i), .filt_on_o(filt)
  );

  // broadcast target set: populated sockets other than this one
  for (genvar n = 0; n < NODES; n++) begin : g_bmask
    assign bmask[n] = (n != HOME) && (SCW'(n) < sockets_i);
  end

  always_comb begin
    directed = filt && hit && (owner != req_node_i);
    evict    = filt && !hit && !free;
    pv_d     = '0;
    cnt_d    = '0;
    if (!filt) begin
      pv_d = bmask;
      for (int n = 0; n < NODES; n++) if (bmask[n]) cnt_d = cnt_d + 1'b1;
      cnt_d = cnt_d + 1'b1;
    end else if (directed) begin
      pv_d[owner] = 1'b1;
      cnt_d       = CW'(1);
    end else if (evict) begin
      pv_d[vic_owner] = 1'b1;
      cnt_d           = CW'(1);
    end
    inv_d   = evict;
    mem_d   = !directed;
    paddr_d = evict ? {vic_tag, lk_set} : req_addr_i;
    way_sel = hit ? hit_way : alloc_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe_vec_q <= '0;
      inv_q       <= 1'b0;
      mem_q       <= 1'b0;
    end else begin
      probe_vec_q <= req_valid_i ? pv_d : '0;
      inv_q       <= req_valid_i && inv_d;
      mem_q       <= req_valid_i && mem_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid_i) begin
      ptid_q  <= req_tid_i;
      paddr_q <= paddr_d;
    end
  end

  pf_dir #(.SETS(SETS), .WAYS(WAYS), .TW(TW), .NW(NW)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .lk_set_i(lk_set), .lk_tag_i(lk_tag),
    .lk_hit_o(hit), .lk_hit_way_o(hit_way), .lk_owner_o(owner),
    .lk_free_o(free), .lk_alloc_way_o(alloc_way),
    .vic_tag_o(vic_tag), .vic_owner_o(vic_owner),
    .adv_en_i(req_valid_i && evict),
    .wr_en_i(dw_en), .wr_set_i(dw_set), .wr_way_i(dw_way),
    .wr_tag_i(dw_tag), .wr_owner_i(dw_owner)
  );

  pf_txn #(.NTID(NTID), .NW(NW), .SW(SW), .WW(WW), .TW(TW), .CW(CW)) u_txn (
    .clk(clk), .rst_n(rst_n),
    .alloc_en_i(req_valid_i), .alloc_tid_i(req_tid_i), .alloc_cnt_i(cnt_d),
    .alloc_node_i(req_node_i), .alloc_upd_i(filt), .alloc_set_i(lk_set),
    .alloc_way_i(way_sel), .alloc_tag_i(lk_tag),
    .rsp_valid_i(rsp_valid_i), .rsp_tid_i(rsp_tid_i),
    .done_valid_o(done_valid_o), .done_tid_o(done_tid_o), .done_node_o(done_node_o),
    .dw_en_o(dw_en), .dw_set_o(dw_set), .dw_way_o(dw_way),
    .dw_tag_o(dw_tag), .dw_owner_o(dw_owner)
  );

  assign probe_vec_o  = probe_vec_q;
  assign probe_inv_o  = inv_q;
  assign probe_tid_o  = ptid_q;
  assign probe_addr_o = paddr_q;
  assign mem_rd_o     = mem_q;
endmodule

// File: rtl/pf_home_chk.sv
module pf_home_chk #(
  parameter int NODES = 4,
  parameter int HOME  = 1,
  parameter int NTID  = 4,
  localparam int IW   = $clog2(NTID)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             req_valid_i,
  input logic [IW-1:0]    req_tid_i,
  input logic [NODES-1:0] probe_vec_o,
  input logic             probe_inv_o,
  input logic [IW-1:0]    probe_tid_o,
  input logic             mem_rd_o,
  input logic             done_valid_o,
  input logic [IW-1:0]    done_tid_o
);
  // R2: the home node is never a probe target
  p_home_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_vec_o[HOME] == 1'b0);

  // R7: an invalidating probe goes to exactly one holder
  p_inv_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    probe_inv_o |-> ($countones(probe_vec_o) == 1));

  // R4: with filtering forced, no request fans out to more than one node
  p_forced_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 2'd2) |-> ($countones(probe_vec_o) <= 1));

  // R4: a directed probe in forced mode never comes with a memory read
  p_directed_nomem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((probe_vec_o != '0) && !probe_inv_o && ($past(mode_i) == 2'd2)) |-> !mem_rd_o);

  // R12: probes follow a request by one cycle and carry its ID
  p_probe_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_vec_o != '0) |-> ($past(req_valid_i) && (probe_tid_o == $past(req_tid_i))));

  // R9: a completion pulse is never repeated for the same ID back to back
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_o |=> !(done_valid_o && (done_tid_o == $past(done_tid_o))));
endmodule

bind pf_home pf_home_chk #(.NODES(NODES), .HOME(HOME), .NTID(NTID)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
  .req_valid_i(req_valid_i), .req_tid_i(req_tid_i),
  .probe_vec_o(probe_vec_o), .probe_inv_o(probe_inv_o), .probe_tid_o(probe_tid_o),
  .mem_rd_o(mem_rd_o), .done_valid_o(done_valid_o), .done_tid_o(done_tid_o)
);

// File: tb/tb_pf_home.sv
module tb_pf_home;
  localparam int CLK_P = 10;
  localparam int NODES = 4;
  localparam int HOME  = 1;
  localparam int AW    = 8;
  localparam int SETS  = 4;
  localparam int WAYS  = 2;
  localparam int NTID  = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [2:0] sockets;
  logic       req_valid;
  logic [1:0] req_node;
  logic [1:0] req_tid;
  logic [7:0] req_addr;
  logic       rsp_valid;
  logic [1:0] rsp_tid;
  logic [3:0] probe_vec;
  logic       probe_inv;
  logic [1:0] probe_tid;
  logic [7:0] probe_addr;
  logic       mem_rd;
  logic       done_valid;
  logic [1:0] done_tid;
  logic [1:0] done_node;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int d_val [SETS][WAYS];
  int d_tag [SETS][WAYS];
  int d_own [SETS][WAYS];
  int d_rr  [SETS];
  int p_v [NTID];
  int p_c [NTID];
  int p_n [NTID];
  int p_u [NTID];
  int p_s [NTID];
  int p_w [NTID];
  int p_t [NTID];

  always #(CLK_P/2) clk = ~clk;

  pf_home #(.NODES(NODES), .HOME(HOME), .AW(AW), .SETS(SETS), .WAYS(WAYS), .NTID(NTID)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .sockets_i(sockets),
    .req_valid_i(req_valid), .req_node_i(req_node), .req_tid_i(req_tid), .req_addr_i(req_addr),
    .rsp_valid_i(rsp_valid), .rsp_tid_i(rsp_tid),
    .probe_vec_o(probe_vec), .probe_inv_o(probe_inv), .probe_tid_o(probe_tid),
    .probe_addr_o(probe_addr), .mem_rd_o(mem_rd),
    .done_valid_o(done_valid), .done_tid_o(done_tid), .done_node_o(done_node)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // one clock of stimulus; expectations come from the reference state, compared at the next falling edge
  task automatic cyc(input bit rv, input int rn, input int rt, input int ra,
                     input bit sv, input int st, input string rq);
    int e_vec, e_inv, e_addr, e_mem, e_done, e_dtid, e_dnode;
    int cnt, s, tg, hw, fw, hit, free, filt, way, sel, ev;
    e_vec = 0; e_inv = 0; e_addr = ra; e_mem = 0; e_done = 0; e_dtid = 0; e_dnode = 0;
    cnt = 0; hw = 0; fw = 0; hit = 0; free = 0; ev = 0; sel = -1;
    filt = (mode == 2'd2 || (mode == 2'd1 && sockets > 3'd2)) ? 1 : 0;
    s  = ra % SETS;
    tg = ra / SETS;
    for (int w = 0; w < WAYS; w++) begin
      if (d_val[s][w] == 1 && d_tag[s][w] == tg && hit == 0) begin hit = 1; hw = w; end
      if (d_val[s][w] == 0 && free == 0) begin free = 1; fw = w; end
    end
    if (rv) begin
      if (filt == 0) begin
        for (int n = 0; n < NODES; n++)
          if (n != HOME && n < int'(sockets)) begin e_vec |= (1 << n); cnt++; end
        cnt++;
        e_mem = 1;
      end else if (hit == 1 && d_own[s][hw] != rn) begin
        e_vec = 1 << d_own[s][hw];
        cnt = 1;
      end else if (hit == 0 && free == 0) begin
        ev = 1;
        e_vec  = 1 << d_own[s][d_rr[s]];
        e_inv  = 1;
        e_addr = d_tag[s][d_rr[s]] * SETS + s;
        cnt = 1;
        e_mem = 1;
      end else begin
        e_mem = 1;
      end
    end
    way = (hit == 1) ? hw : ((free == 1) ? fw : d_rr[s]);
    for (int t = 0; t < NTID; t++)
      if (p_v[t] == 1 && p_c[t] == 0 && sel < 0) sel = t;
    if (sel >= 0) begin
      e_done = 1; e_dtid = sel; e_dnode = p_n[sel];
      p_v[sel] = 0;
      if (p_u[sel] == 1) begin
        d_val[p_s[sel]][p_w[sel]] = 1;
        d_tag[p_s[sel]][p_w[sel]] = p_t[sel];
        d_own[p_s[sel]][p_w[sel]] = p_n[sel];
      end
    end
    if (sv && p_v[st] == 1 && p_c[st] > 0) p_c[st]--;
    if (rv) begin
      p_v[rt] = 1; p_c[rt] = cnt; p_n[rt] = rn; p_u[rt] = filt;
      p_s[rt] = s; p_w[rt] = way; p_t[rt] = tg;
    end
    if (ev == 1) d_rr[s] = (d_rr[s] + 1) % WAYS;

    req_valid = rv;
    req_node  = 2'(rn);
    req_tid   = 2'(rt);
    req_addr  = 8'(ra);
    rsp_valid = sv;
    rsp_tid   = 2'(st);
    @(negedge clk);
    chk(int'(probe_vec) == e_vec, rq, "probe vector", int'(probe_vec), e_vec);
    chk(int'(mem_rd) == e_mem, rq, "memory read", int'(mem_rd), e_mem);
    if (e_vec != 0) begin
      chk(int'(probe_inv) == e_inv, rq, "probe invalidate", int'(probe_inv), e_inv);
      chk(int'(probe_addr) == e_addr, "R12", "probe address", int'(probe_addr), e_addr);
      chk(int'(probe_tid) == (rt % NTID), "R12", "probe ID", int'(probe_tid), rt);
    end
    chk(int'(done_valid) == e_done, "R9", "done pulse", int'(done_valid), e_done);
    if (e_done == 1) begin
      chk(int'(done_tid) == e_dtid, "R9", "done ID", int'(done_tid), e_dtid);
      chk(int'(done_node) == e_dnode, "R9", "done node", int'(done_node), e_dnode);
    end
  endtask

  task automatic idle(input string rq);
    cyc(0, 0, 0, 0, 0, 0, rq);
  endtask

  task automatic rsp(input int t, input string rq);
    cyc(0, 0, 0, 0, 1, t, rq);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R9: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      d_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin d_val[s][w] = 0; d_tag[s][w] = 0; d_own[s][w] = 0; end
    end
    for (int t = 0; t < NTID; t++) begin
      p_v[t] = 0; p_c[t] = 0; p_n[t] = 0; p_u[t] = 0; p_s[t] = 0; p_w[t] = 0; p_t[t] = 0;
    end
    rst_n = 1'b0; mode = 2'd2; sockets = 3'd4;
    req_valid = 0; req_node = 0; req_tid = 0; req_addr = 0; rsp_valid = 0; rsp_tid = 0;
    repeat (3) @(negedge clk);
    chk(probe_vec == 4'd0, "R1", "probe vector in reset", int'(probe_vec), 0);
    chk(mem_rd == 1'b0, "R1", "memory read in reset", int'(mem_rd), 0);
    chk(done_valid == 1'b0, "R1", "done in reset", int'(done_valid), 0);
    rst_n = 1'b1;
    idle("R1");

    // forced filter, fill set 0
    cyc(1, 0, 0, 'h10, 0, 0, "R5"); idle("R5"); idle("R9");
    cyc(1, 2, 1, 'h10, 0, 0, "R4"); rsp(1, "R4"); idle("R8"); idle("R9");
    cyc(1, 2, 2, 'h10, 0, 0, "R6"); idle("R6"); idle("R9");
    cyc(1, 3, 3, 'h20, 0, 0, "R5"); idle("R5"); idle("R9");
    // conflicts rotate through the ways
    cyc(1, 0, 0, 'h30, 0, 0, "R7"); rsp(0, "R7"); idle("R7"); idle("R9");
    cyc(1, 2, 1, 'h40, 0, 0, "R7"); rsp(1, "R7"); idle("R7"); idle("R9");
    // filter off: broadcast, directory untouched
    mode = 2'd0;
    cyc(1, 3, 2, 'h30, 0, 0, "R2");
    for (int i = 0; i < 4; i++) rsp(2, "R2");
    idle("R2"); idle("R9");
    mode = 2'd2;
    cyc(1, 2, 3, 'h30, 0, 0, "R10"); rsp(3, "R10"); idle("R10"); idle("R9");
    // auto mode at two and three sockets, reserved encoding
    mode = 2'd1; sockets = 3'd2;
    cyc(1, 0, 0, 'h30, 0, 0, "R3"); rsp(0, "R3"); rsp(0, "R3"); idle("R3"); idle("R9");
    sockets = 3'd3;
    cyc(1, 0, 1, 'h30, 0, 0, "R3"); rsp(1, "R3"); idle("R3"); idle("R9");
    mode = 2'd3;
    cyc(1, 2, 2, 'h30, 0, 0, "R3");
    for (int i = 0; i < 3; i++) rsp(2, "R3");
    idle("R3"); idle("R9");
    // overlapping IDs, responses out of order
    mode = 2'd2; sockets = 3'd4;
    cyc(1, 3, 0, 'h30, 0, 0, "R11");
    cyc(1, 0, 1, 'h40, 0, 0, "R11");
    rsp(1, "R11"); idle("R11"); rsp(0, "R11"); idle("R11"); idle("R9");
    // requester of the last completion is now the recorded holder
    cyc(1, 0, 2, 'h30, 0, 0, "R8"); rsp(2, "R8"); idle("R8"); idle("R9");
    finish_run();
  end
endmodule